// File: doc/BRIEF.md
# Multi-Mode Event Counter with Compare and Watchdog

This block is a 32-bit up/down counter that sits behind a small word-addressed register port. It has a preload register and a compare register. Steps can come from three sources. The first is a free-running internal tick divided by 1, 2, 4 or 8. The second is a pair of external lines, used either as separate up and down pulse inputs or as a clock and a direction level. The third is those same two lines decoded as a quadrature encoder. A count mode sets what happens when the value runs down past zero: it wraps freely, it reloads from preload to give a divide-by-N period, or it stops at zero until software reloads it.

A third external line, the control line, serves one function chosen in the control register. It can load the preload value on any level change, clear the counter on any level change, or gate counting while it is high. In watchdog mode it instead forces downward counting, so that any level change or a load command re-arms the counter from preload. If the counter reaches zero first, a timeout is flagged. Compare matches, wrap-under from zero and watchdog timeouts each latch a status bit that is cleared by writing one. Match and timeout can each drive the interrupt output.

Top module: `multimode_counter`

## Requirements
- R1: While reset is held, every readable register (control at address 0, status at 1, preload at 3, compare at 4, counter at 5) reads 0 and `irq` is 0.
- R2: Preload (address 3), compare (address 4) and counter (address 5) take a write only when all four byte enables are set. A write with any byte enable clear leaves the register unchanged.
- R3: Writing address 2 with bit 0 set copies preload into the counter. Writing it with bit 1 set clears the counter, and the clear wins if both bits are set. Address 2 always reads 0.
- R4: With source select 0 (control bits [1:0]), the counter steps once every 2^p clock cycles, where p is control bits [8:7]. It steps down when control bit 9 is 1 and up otherwise.
- R5: With source select 1, a rising edge on `cntInA` adds one and a rising edge on `cntInB` subtracts one. Simultaneous edges cancel.
- R6: With source select 2, a rising edge on `cntInA` steps the counter: down when `cntInB` is high, up when it is low.
- R7: With source select 3, `{cntInA,cntInB}` steps up on 00→01→11→10→00, steps down on the reverse order, and ignores changes of both lines at once.
- R8: In cycling mode (control bits [3:2] = 0), a down step from 0 gives 0xFFFFFFFF and sets status bit 1. Writing 1 to that bit clears it.
- R9: In divide-by-N mode (bits [3:2] = 1), a down step from 1 or 0 loads preload instead, and status bit 1 is not set.
- R10: In single mode (bits [3:2] = 2), a counter at 0 ignores up and down steps until it is loaded or written.
- R11: With control-line function 1 (control bits [6:4]), every level change of `ctlIn` loads preload. With function 2, every level change clears the counter.
- R12: With control-line function 3, the counter steps only while `ctlIn` is high.
- R13: With control-line function 4, every step counts down. A level change of `ctlIn` or a load command reloads preload. A step from 1 to 0 sets status bit 2, and the counter then holds at 0. `irq` follows status bit 2 when control bit 11 is set.
- R14: Status bit 0 sets when the counter takes the compare value from a different value, and writing 1 clears it. `irq` follows it only when control bit 10 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Word address for read and write |
| wrData | input | 32 | Write data |
| wrByteEn | input | 4 | Byte lane enables for the write |
| rdData | output | 32 | Read data for `regAddr` (combinational) |
| cntInA | input | 1 | Count line A (up pulse, clock or quadrature phase A) |
| cntInB | input | 1 | Count line B (down pulse, direction or quadrature phase B) |
| ctlIn | input | 1 | Control line (load, clear, gate or watchdog kick) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the watchdog timeout. It must follow a reload that came from the control line rather than a command. The counter is running down on the internal tick, so the bench must kick the line partway through, confirm that no timeout has occurred and that the value jumped back near preload, and only then let the count expire. The quadrature decoder also needs illegal double changes mixed with reversals in both directions. A vector table walks these transitions from a known start value and carries the expected count after each step.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  localparam int unsigned STAT_W = 3;
  localparam int unsigned PRESC_SEL_W = 2;
  localparam int unsigned CTRL_W = 12;

  localparam int unsigned REG_CTRL    = 0;
  localparam int unsigned REG_STAT    = 1;
  localparam int unsigned REG_CMD     = 2;
  localparam int unsigned REG_PRELOAD = 3;
  localparam int unsigned REG_COMPARE = 4;
  localparam int unsigned REG_COUNT   = 5;

  typedef enum logic [1:0] {IN_INTERNAL, IN_UPDOWN, IN_DIRECTION, IN_QUAD} inSel_e;
  typedef enum logic [1:0] {CM_CYCLE, CM_DIVN, CM_SINGLE, CM_SPARE} cntMode_e;
  typedef enum logic [2:0] {CTL_NONE, CTL_LOAD, CTL_RESET, CTL_GATE, CTL_WATCHDOG,
                            CTL_SP5, CTL_SP6, CTL_SP7} ctlSel_e;

  typedef struct packed {
    logic     wrCount;
    logic     wrPreload;
    logic     wrCompare;
    logic     cmdLoad;
    logic     cmdReset;
    logic     ctlLoad;
    logic     ctlReset;
    logic     stepUp;
    logic     stepDn;
    logic     watchdog;
    cntMode_e mode;
  } dpStrobe_t;

  typedef struct packed {
    logic timeout;
    logic underflow;
    logic match;
  } dpEvent_t;
endpackage

// File: rtl/mmc_input_decode.sv
module mmc_input_decode
  import mmc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lineA,
  input  logic                   lineB,
  input  logic                   ctlLine,
  input  inSel_e                 inSel,
  input  logic [PRESC_SEL_W-1:0] prescSel,
  input  logic                   intDown,
  output logic                   rawUp,
  output logic                   rawDn,
  output logic                   ctlChange,
  output logic                   ctlLevel
);
  localparam int unsigned N_LINES = 3;
  localparam int unsigned PRESC_W = (1 << PRESC_SEL_W) - 1;

  logic [N_LINES-1:0] lineIn;
  logic [N_LINES-1:0] syncQ;
  logic [N_LINES-1:0] prevQ;
  logic [SYNC_STAGES-1:0] shReg [N_LINES];

  assign lineIn = {ctlLine, lineB, lineA};

  for (genvar i = 0; i < N_LINES; i++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shReg[i] <= '0;
      else       shReg[i] <= {shReg[i][SYNC_STAGES-2:0], lineIn[i]};
    end
    assign syncQ[i] = shReg[i][SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ;
  end

  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescMask;
  logic tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prescCnt <= '0;
    else       prescCnt <= prescCnt + 1'b1;
  end

  assign prescMask = PRESC_W'((32'd1 << prescSel) - 32'd1);
  assign tick = (prescCnt & prescMask) == '0;

  logic riseA, riseB, quadUp, quadDn;
  assign riseA = syncQ[0] & ~prevQ[0];
  assign riseB = syncQ[1] & ~prevQ[1];

  always_comb begin
    quadUp = 1'b0;
    quadDn = 1'b0;
    case ({prevQ[0], prevQ[1], syncQ[0], syncQ[1]})
      4'b0001, 4'b0111, 4'b1110, 4'b1000: quadUp = 1'b1;
      4'b0100, 4'b1101, 4'b1011, 4'b0010: quadDn = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (inSel)
      IN_INTERNAL:  begin rawUp = tick & ~intDown;  rawDn = tick & intDown;   end
      IN_UPDOWN:    begin rawUp = riseA & ~riseB;   rawDn = riseB & ~riseA;   end
      IN_DIRECTION: begin rawUp = riseA & ~syncQ[1]; rawDn = riseA & syncQ[1]; end
      default:      begin rawUp = quadUp;           rawDn = quadDn;           end
    endcase
  end

  assign ctlChange = syncQ[2] ^ prevQ[2];
  assign ctlLevel  = syncQ[2];
endmodule

// File: rtl/mmc_control.sv
module mmc_control
  import mmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned BE_W   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [CTRL_W-1:0]      wrLow,
  input  logic [BE_W-1:0]        wrByteEn,
  input  logic                   rawUp,
  input  logic                   rawDn,
  input  logic                   ctlChange,
  input  logic                   ctlLevel,
  input  dpEvent_t               evt,
  output dpStrobe_t              strobe,
  output inSel_e                 inSel,
  output logic [PRESC_SEL_W-1:0] prescSel,
  output logic                   intDown,
  output logic [CTRL_W-1:0]      ctrlWord,
  output logic [STAT_W-1:0]      status,
  output logic                   irq
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [STAT_W-1:0] statQ;
  logic fullWord, selCtrl, selStat, selCmd;
  ctlSel_e ctlSel;
  cntMode_e cntMode;
  logic matchIe, timeoutIe, isWd, gateOpen;

  assign fullWord = wrByteEn == '1;
  assign selCtrl  = wrEn && (regAddr == ADDR_W'(REG_CTRL));
  assign selStat  = wrEn && (regAddr == ADDR_W'(REG_STAT));
  assign selCmd   = wrEn && (regAddr == ADDR_W'(REG_CMD));

  assign inSel     = inSel_e'(ctrlQ[1:0]);
  assign cntMode   = cntMode_e'(ctrlQ[3:2]);
  assign ctlSel    = ctlSel_e'(ctrlQ[6:4]);
  assign prescSel  = ctrlQ[8:7];
  assign intDown   = ctrlQ[9];
  assign matchIe   = ctrlQ[10];
  assign timeoutIe = ctrlQ[11];

  assign isWd     = ctlSel == CTL_WATCHDOG;
  assign gateOpen = (ctlSel != CTL_GATE) || ctlLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctrlQ <= '0;
    else if (selCtrl) ctrlQ <= wrLow;
  end

  always_comb begin
    strobe.wrCount   = wrEn && fullWord && (regAddr == ADDR_W'(REG_COUNT));
    strobe.wrPreload = wrEn && fullWord && (regAddr == ADDR_W'(REG_PRELOAD));
    strobe.wrCompare = wrEn && fullWord && (regAddr == ADDR_W'(REG_COMPARE));
    strobe.cmdLoad   = selCmd && wrLow[0];
    strobe.cmdReset  = selCmd && wrLow[1];
    strobe.ctlLoad   = ctlChange && ((ctlSel == CTL_LOAD) || isWd);
    strobe.ctlReset  = ctlChange && (ctlSel == CTL_RESET);
    strobe.stepUp    = gateOpen && !isWd && rawUp;
    strobe.stepDn    = gateOpen && (isWd ? (rawUp || rawDn) : rawDn);
    strobe.watchdog  = isWd;
    strobe.mode      = cntMode;
  end

  logic [STAT_W-1:0] clrVec, setVec;
  assign clrVec = selStat ? wrLow[STAT_W-1:0] : '0;
  assign setVec = {evt.timeout, evt.underflow, evt.match};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrVec) | setVec;
  end

  assign ctrlWord = ctrlQ;
  assign status   = statQ;
  assign irq      = (statQ[0] & matchIe) | (statQ[2] & timeoutIe);
endmodule

// File: rtl/mmc_datapath.sv
module mmc_datapath
  import mmc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] preload,
  output logic [DATA_W-1:0] compare,
  output dpEvent_t          evt
);
  logic [DATA_W-1:0] cntQ, cntNext, preQ, cmpQ;
  logic atZero, atOne, ufEvt, toEvt;

  assign atZero = cntQ == '0;
  assign atOne  = cntQ == DATA_W'(1);

  always_comb begin
    cntNext = cntQ;
    ufEvt   = 1'b0;
    toEvt   = 1'b0;
    if (strobe.wrCount)                        cntNext = wrData;
    else if (strobe.cmdReset)                  cntNext = '0;
    else if (strobe.cmdLoad || strobe.ctlLoad) cntNext = preQ;
    else if (strobe.ctlReset)                  cntNext = '0;
    else if (strobe.stepUp) begin
      if (!(atZero && strobe.mode == CM_SINGLE)) cntNext = cntQ + 1'b1;
    end else if (strobe.stepDn) begin
      if (strobe.watchdog) begin
        if (!atZero) begin
          cntNext = cntQ - 1'b1;
          toEvt   = atOne;
        end
      end else begin
        case (strobe.mode)
          CM_SINGLE: if (!atZero) cntNext = cntQ - 1'b1;
          CM_DIVN:   cntNext = (atZero || atOne) ? preQ : cntQ - 1'b1;
          default: begin
            cntNext = cntQ - 1'b1;
            ufEvt   = atZero;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      preQ <= '0;
      cmpQ <= '0;
    end else begin
      cntQ <= cntNext;
      if (strobe.wrPreload) preQ <= wrData;
      if (strobe.wrCompare) cmpQ <= wrData;
    end
  end

  assign evt.match     = (cntNext != cntQ) && (cntNext == cmpQ);
  assign evt.underflow = ufEvt;
  assign evt.timeout   = toEvt;
  assign count   = cntQ;
  assign preload = preQ;
  assign compare = cmpQ;
endmodule

// File: rtl/multimode_counter.sv
module multimode_counter
  import mmc_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W/8-1:0] wrByteEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              cntInA,
  input  logic              cntInB,
  input  logic              ctlIn,
  output logic              irq
);
  localparam int unsigned BE_W = DATA_W / 8;

  dpStrobe_t strobe;
  dpEvent_t  evt;
  inSel_e    inSel;
  logic [PRESC_SEL_W-1:0] prescSel;
  logic intDown, rawUp, rawDn, ctlChange, ctlLevel;
  logic [CTRL_W-1:0] ctrlWord;
  logic [STAT_W-1:0] statusBits;
  logic [DATA_W-1:0] cntValue, preloadValue, compareValue;

  mmc_input_decode #(.SYNC_STAGES(SYNC_STAGES)) uDecode (
    .clk(clk), .rstN(rstN), .lineA(cntInA), .lineB(cntInB), .ctlLine(ctlIn),
    .inSel(inSel), .prescSel(prescSel), .intDown(intDown),
    .rawUp(rawUp), .rawDn(rawDn), .ctlChange(ctlChange), .ctlLevel(ctlLevel)
  );

  mmc_control #(.ADDR_W(ADDR_W), .BE_W(BE_W)) uControl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrLow(wrData[CTRL_W-1:0]), .wrByteEn(wrByteEn),
    .rawUp(rawUp), .rawDn(rawDn), .ctlChange(ctlChange), .ctlLevel(ctlLevel),
    .evt(evt), .strobe(strobe), .inSel(inSel), .prescSel(prescSel),
    .intDown(intDown), .ctrlWord(ctrlWord), .status(statusBits), .irq(irq)
  );

  mmc_datapath #(.DATA_W(DATA_W)) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .count(cntValue), .preload(preloadValue), .compare(compareValue), .evt(evt)
  );

  always_comb begin
    case (regAddr)
      ADDR_W'(REG_CTRL):    rdData = DATA_W'(ctrlWord);
      ADDR_W'(REG_STAT):    rdData = DATA_W'(statusBits);
      ADDR_W'(REG_PRELOAD): rdData = preloadValue;
      ADDR_W'(REG_COMPARE): rdData = compareValue;
      ADDR_W'(REG_COUNT):   rdData = cntValue;
      default:              rdData = '0;
    endcase
  end
endmodule

// File: rtl/mmc_checker.sv
module mmc_checker
  import mmc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W/8-1:0] wrByteEn,
  input logic [DATA_W-1:0] cntValue,
  input logic [DATA_W-1:0] preloadValue,
  input logic [DATA_W-1:0] compareValue,
  input logic [STAT_W-1:0] statusBits
);
  a_r2_narrow_preload: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(REG_PRELOAD) && wrByteEn != '1) |=> $stable(preloadValue));

  a_r3_cmd_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_W'(REG_CMD) && wrData[1]) |=> (cntValue == '0));

  a_r8_underflow_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[1]) |-> ($past(cntValue) == '0 && cntValue == '1));

  a_r13_timeout_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[2]) |-> (cntValue == '0));

  a_r14_match_value: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[0]) |-> (cntValue == $past(compareValue)));
endmodule

bind multimode_counter mmc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .wrByteEn(wrByteEn), .cntValue(cntValue), .preloadValue(preloadValue),
  .compareValue(compareValue), .statusBits(statusBits)
);

// File: tb/multimode_counter_test.sv
`timescale 1ns/100ps
module multimode_counter_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0] wrByteEn = '0;
  logic [31:0] rdData;
  logic cntInA = 1'b0, cntInB = 1'b0, ctlIn = 1'b0;
  logic irq;
  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  multimode_counter uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .wrByteEn(wrByteEn), .rdData(rdData), .cntInA(cntInA), .cntInB(cntInB),
    .ctlIn(ctlIn), .irq(irq)
  );

  // {A,B} then expected count, starting from 100 at A=B=0 (R7)
  localparam logic [33:0] QUAD_VEC [12] = '{
    {2'b01, 32'd101}, {2'b11, 32'd102}, {2'b10, 32'd103}, {2'b00, 32'd104},
    {2'b10, 32'd103}, {2'b11, 32'd102}, {2'b00, 32'd102}, {2'b01, 32'd103},
    {2'b00, 32'd102}, {2'b10, 32'd101}, {2'b01, 32'd101}, {2'b11, 32'd102}};

  function automatic logic [31:0] ctrlVal(int src, int cm, int ctl, int presc,
                                          bit down, bit mie, bit tie);
    return 32'((tie << 11) | (mie << 10) | (down << 9) | (presc << 7) |
               (ctl << 4) | (cm << 2) | src);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [2:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d; wrByteEn = be;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = '0;
  endtask

  task automatic readReg(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseA();
    cntInA = 1'b1; waitCyc(4); cntInA = 1'b0; waitCyc(4);
  endtask

  task automatic pulseB();
    cntInB = 1'b1; waitCyc(4); cntInB = 1'b0; waitCyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    // R1: reset state observed while reset is held
    waitCyc(4);
    for (int a = 0; a < 6; a++) begin
      readReg(3'(a), v);
      check($sformatf("R1 reg%0d reset", a), v, 32'h0);
    end
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    @(negedge clk) rstN = 1'b1;
    writeReg(3'd0, ctrlVal(1, 0, 0, 0, 0, 0, 0));

    // R2: narrow writes rejected, full writes accepted
    writeReg(3'd3, 32'hAAAA_5555, 4'b0011);
    readReg(3'd3, v); check("R2 narrow preload", v, 32'h0);
    writeReg(3'd3, 32'h0000_1234);
    readReg(3'd3, v); check("R2 full preload", v, 32'h0000_1234);
    writeReg(3'd4, 32'hFFFF_0000);
    readReg(3'd4, v); check("R2 full compare", v, 32'hFFFF_0000);
    writeReg(3'd5, 32'h0000_0010);
    writeReg(3'd5, 32'h1111_1111, 4'b1110);
    readReg(3'd5, v); check("R2 narrow count", v, 32'h0000_0010);

    // R3: command bits
    writeReg(3'd2, 32'h1);
    readReg(3'd5, v); check("R3 load cmd", v, 32'h0000_1234);
    writeReg(3'd2, 32'h3);
    readReg(3'd5, v); check("R3 clear wins", v, 32'h0);
    readReg(3'd2, v); check("R3 cmd reads zero", v, 32'h0);

    // R5: separate up/down lines
    writeReg(3'd5, 32'd50);
    pulseA(); pulseA(); pulseA();
    readReg(3'd5, v); check("R5 up edges", v, 32'd53);
    pulseB();
    readReg(3'd5, v); check("R5 down edge", v, 32'd52);

    // R6: clock plus direction level
    writeReg(3'd0, ctrlVal(2, 0, 0, 0, 0, 0, 0));
    writeReg(3'd5, 32'd10);
    pulseA();
    readReg(3'd5, v); check("R6 dir low up", v, 32'd11);
    cntInB = 1'b1; waitCyc(5);
    readReg(3'd5, v); check("R6 level alone", v, 32'd11);
    pulseA(); pulseA();
    readReg(3'd5, v); check("R6 dir high down", v, 32'd9);
    cntInB = 1'b0; waitCyc(5);

    // R7: quadrature table walk
    writeReg(3'd0, ctrlVal(3, 0, 0, 0, 0, 0, 0));
    writeReg(3'd5, 32'd100);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {cntInA, cntInB} = QUAD_VEC[i][33:32];
      waitCyc(5);
      readReg(3'd5, v);
      check($sformatf("R7 quad step %0d", i), v, QUAD_VEC[i][31:0]);
    end
    writeReg(3'd0, ctrlVal(1, 0, 0, 0, 0, 0, 0));
    cntInA = 1'b0; cntInB = 1'b0; waitCyc(5);

    // R8: underflow wrap and flag
    writeReg(3'd5, 32'd1);
    pulseB();
    readReg(3'd1, v); check("R8 no flag at zero", v & 32'h2, 32'h0);
    pulseB();
    readReg(3'd5, v); check("R8 wrap value", v, 32'hFFFF_FFFF);
    readReg(3'd1, v); check("R8 flag set", v & 32'h2, 32'h2);
    writeReg(3'd1, 32'h2);
    readReg(3'd1, v); check("R8 flag cleared", v & 32'h2, 32'h0);

    // R9: divide-by-N reload
    writeReg(3'd0, ctrlVal(1, 1, 0, 0, 0, 0, 0));
    writeReg(3'd3, 32'd3);
    writeReg(3'd5, 32'd3);
    pulseB(); pulseB();
    readReg(3'd5, v); check("R9 down to one", v, 32'd1);
    pulseB();
    readReg(3'd5, v); check("R9 reload", v, 32'd3);
    readReg(3'd1, v); check("R9 no underflow", v & 32'h2, 32'h0);

    // R10: single cycle stops at zero
    writeReg(3'd0, ctrlVal(1, 2, 0, 0, 0, 0, 0));
    writeReg(3'd5, 32'd2);
    pulseB(); pulseB(); pulseB();
    readReg(3'd5, v); check("R10 hold after down", v, 32'd0);
    pulseA();
    readReg(3'd5, v); check("R10 hold after up", v, 32'd0);
    writeReg(3'd2, 32'h1);
    readReg(3'd5, v); check("R10 reload", v, 32'd3);

    // R14: compare match flag and interrupt enable
    writeReg(3'd1, 32'h7);
    writeReg(3'd0, ctrlVal(1, 0, 0, 0, 0, 1, 0));
    writeReg(3'd4, 32'd5);
    writeReg(3'd5, 32'd3);
    pulseA();
    readReg(3'd1, v); check("R14 no early match", v & 32'h1, 32'h0);
    pulseA();
    readReg(3'd1, v); check("R14 match flag", v & 32'h1, 32'h1);
    check("R14 irq enabled", {31'b0, irq}, 32'h1);
    writeReg(3'd1, 32'h1);
    readReg(3'd1, v); check("R14 match cleared", v & 32'h1, 32'h0);
    check("R14 irq cleared", {31'b0, irq}, 32'h0);
    writeReg(3'd0, ctrlVal(1, 0, 0, 0, 0, 0, 0));
    writeReg(3'd5, 32'd4);
    pulseA();
    readReg(3'd1, v); check("R14 match masked flag", v & 32'h1, 32'h1);
    check("R14 irq masked", {31'b0, irq}, 32'h0);
    writeReg(3'd1, 32'h7);

    // R11: control line load and clear on either level change
    writeReg(3'd0, ctrlVal(1, 0, 1, 0, 0, 0, 0));
    writeReg(3'd3, 32'd77);
    ctlIn = 1'b1; waitCyc(5);
    readReg(3'd5, v); check("R11 load on rise", v, 32'd77);
    writeReg(3'd5, 32'd5);
    ctlIn = 1'b0; waitCyc(5);
    readReg(3'd5, v); check("R11 load on fall", v, 32'd77);
    writeReg(3'd0, ctrlVal(1, 0, 2, 0, 0, 0, 0));
    ctlIn = 1'b1; waitCyc(5);
    readReg(3'd5, v); check("R11 clear on change", v, 32'd0);

    // R4: internal prescaled tick, rate and direction
    writeReg(3'd5, 32'd1000);
    writeReg(3'd0, ctrlVal(0, 0, 0, 0, 0, 0, 0));
    readReg(3'd5, v); waitCyc(39); readReg(3'd5, v2);
    check("R4 div1 up", v2 - v, 32'd40);
    writeReg(3'd0, ctrlVal(0, 0, 0, 2, 1, 0, 0));
    readReg(3'd5, v); waitCyc(39); readReg(3'd5, v2);
    check("R4 div4 down", v - v2, 32'd10);
    writeReg(3'd0, ctrlVal(0, 0, 0, 3, 0, 0, 0));
    readReg(3'd5, v); waitCyc(39); readReg(3'd5, v2);
    check("R4 div8 up", v2 - v, 32'd5);

    // R12: gate
    writeReg(3'd0, ctrlVal(0, 0, 3, 0, 0, 0, 0));
    ctlIn = 1'b0; waitCyc(5);
    readReg(3'd5, v); waitCyc(19); readReg(3'd5, v2);
    check("R12 gate closed", v2 - v, 32'd0);
    ctlIn = 1'b1; waitCyc(5);
    readReg(3'd5, v); waitCyc(19); readReg(3'd5, v2);
    check("R12 gate open", v2 - v, 32'd20);

    // R13: watchdog reload by control line, then timeout
    writeReg(3'd3, 32'd20);
    writeReg(3'd0, ctrlVal(0, 0, 4, 0, 0, 0, 1));
    writeReg(3'd1, 32'h7);
    writeReg(3'd2, 32'h1);
    waitCyc(10);
    readReg(3'd1, v); check("R13 no early timeout", v & 32'h4, 32'h0);
    ctlIn = 1'b0; waitCyc(4);
    readReg(3'd5, v); check("R13 kicked reload", {31'b0, (v > 32'd14 && v <= 32'd20)}, 32'h1);
    readReg(3'd1, v); check("R13 still armed", v & 32'h4, 32'h0);
    waitCyc(40);
    readReg(3'd5, v); check("R13 holds zero", v, 32'd0);
    readReg(3'd1, v); check("R13 timeout flag", v & 32'h4, 32'h4);
    check("R13 timeout irq", {31'b0, irq}, 32'h1);
    writeReg(3'd1, 32'h4);
    readReg(3'd1, v); check("R13 timeout cleared", v & 32'h4, 32'h0);
    check("R13 irq cleared", {31'b0, irq}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule